// File: doc/BRIEF.md
# I2C Command Word Packer

This block turns a batch of I2C messages into a sequence of 32-bit command words for a word-driven I2C engine. Messages arrive as a byte stream. A beat flagged as a header carries the 7-bit target address and the read flag. The data beats of that message follow it, and the batch ends on the beat flagged as the end. Each command word has three byte slots, and every slot has a 2-bit framing tag that tells the engine to begin a transfer, to go on with it, to end it, or to do nothing.

Slots are filled in arrival order, and the filling runs on across message and word boundaries. The block keeps the whole batch in a local word buffer, because it must know the word count before it can emit anything. A batch that needs more words than the buffer holds is rejected as a whole, and none of its words are sent. An accepted batch is then streamed out with a valid/ready handshake, and a last flag marks its final word.

Back-pressure rules: the input is only ready while the block is filling, and it is never ready while a batch is being emitted. The output holds its word, last flag and valid steady for as long as ready stays low. A word counts as transferred only in a cycle where valid and ready are both high.

Top module: `i2c_cmd_packer`

## Requirements
- R1: A header beat becomes the byte {addr[6:0], rd}, with rd in bit 0, and is tagged START (2'b11), unless R3 applies to it.
- R2: A data beat is tagged CONT (2'b10) and takes the next free slot. Slot k of a word holds its byte in bits [31-8k:24-8k] and its tag in bits [7-2k:6-2k], and filling runs on across message and word boundaries.
- R3: If the last beat of a batch is a data beat, its tag is STOP (2'b01). If the last beat is a header, it keeps START.
- R4: Unused slots carry a zero byte and the NOP tag (2'b00), and bits 1:0 of every word are zero.
- R5: An accepted batch of N beats produces exactly 1 + (N-1)/3 words (integer division), and out_words shows that count while the words are emitted.
- R6: If 4 times the word count exceeds BUF_BYTES, err_o pulses for one cycle, which is the cycle after the end beat is accepted, and no word is emitted.
- R7: The output holds valid, data and last stable while ready is low. out_last is high on the final word only, and out_valid drops after that word is transferred.
- R8: in_ready is low while a batch is being emitted, and high again once the final word has been taken.
- R9: After reset, in_ready is 1, out_valid is 0 and err_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Block accepts a beat |
| in_hdr | input | 1 | Beat opens a message (address header) |
| in_rd | input | 1 | Read flag, used on header beats |
| in_data | input | 8 | Address in bits 6:0 on a header, data byte otherwise |
| in_end | input | 1 | Final beat of the batch |
| out_valid | output | 1 | Command word valid |
| out_ready | input | 1 | Downstream takes the word |
| out_data | output | 32 | Command word |
| out_last | output | 1 | Final word of the batch |
| out_words | output | $clog2(BUF_BYTES/4+1) | Word count of the batch being emitted |
| err_o | output | 1 | One-cycle pulse: batch rejected for size |

## Verification
The assertions assume that every batch starts with a header beat and closes with exactly one end beat. They also assume that input signals change only between clock edges. The bench always builds batches from whole messages and puts the end flag on the final beat only. It drives inputs on the falling edge, it throttles out_ready at random to exercise the hold rule, and its batch sizes include the exact buffer limit and one beat beyond it.

// File: rtl/i2c_pack_pkg.sv
package i2c_pack_pkg;
  typedef enum logic [1:0] {
    TAG_NOP   = 2'b00,
    TAG_STOP  = 2'b01,
    TAG_CONT  = 2'b10,
    TAG_START = 2'b11
  } tag_e;
endpackage

// File: rtl/i2c_pack_pos.sv
module i2c_pack_pos #(
  parameter int DEPTH = 8,
  localparam int WW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  input  logic          clear,
  output logic [WW-1:0] word_idx,
  output logic [1:0]    slot_idx,
  output logic          ovf
);
  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      word_idx <= '0;
      slot_idx <= '0;
      ovf      <= 1'b0;
    end else if (step) begin
      if (word_idx >= WW'(DEPTH)) ovf <= 1'b1;
      if (slot_idx == 2'd2) begin
        slot_idx <= '0;
        if (word_idx < WW'(DEPTH)) word_idx <= word_idx + 1'b1;
      end else begin
        slot_idx <= slot_idx + 1'b1;
      end
    end
  end

  // R5
  word_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (word_idx <= WW'(DEPTH)) && (slot_idx != 2'd3));
endmodule

// File: rtl/i2c_pack_wbuf.sv
module i2c_pack_wbuf #(
  parameter int DEPTH = 8,
  localparam int WW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [WW-1:0] wr_word,
  input  logic [1:0]    wr_slot,
  input  logic [7:0]    wr_byte,
  input  logic [1:0]    wr_tag,
  input  logic [WW-1:0] rd_idx,
  output logic [31:0]   rd_data
);
  logic [31:0] mem_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        mem_q[g] <= '0;
      end else if (wr_en && wr_word == WW'(g)) begin
        case (wr_slot)
          2'd0: mem_q[g] <= {wr_byte, 16'h0000, wr_tag, 6'b000000};
          2'd1: begin
            mem_q[g][23:16] <= wr_byte;
            mem_q[g][5:4]   <= wr_tag;
          end
          default: begin
            mem_q[g][15:8] <= wr_byte;
            mem_q[g][3:2]  <= wr_tag;
          end
        endcase
      end
    end
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < DEPTH; i++)
      if (rd_idx == WW'(i)) rd_data = mem_q[i];
  end
endmodule

// File: rtl/i2c_cmd_packer.sv
module i2c_cmd_packer #(
  parameter int BUF_BYTES = 32,
  localparam int DEPTH = BUF_BYTES / 4,
  localparam int WW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic          in_hdr,
  input  logic          in_rd,
  input  logic [7:0]    in_data,
  input  logic          in_end,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [31:0]   out_data,
  output logic          out_last,
  output logic [WW-1:0] out_words,
  output logic          err_o
);
  import i2c_pack_pkg::*;

  typedef enum logic {ST_FILL, ST_SEND} st_e;
  st_e st_q;

  logic [WW-1:0] word_idx, total_q, rd_q;
  logic [1:0]    slot_idx;
  logic          ovf, acc, batch_done, reject_now, wr_en;
  logic [7:0]    beat_byte;
  tag_e          beat_tag;

  assign in_ready   = (st_q == ST_FILL);
  assign out_valid  = (st_q == ST_SEND);
  assign acc        = in_valid && in_ready;
  assign batch_done = acc && in_end;
  assign reject_now = ovf || (word_idx >= WW'(DEPTH));
  assign wr_en      = acc && (word_idx < WW'(DEPTH));
  assign beat_byte  = in_hdr ? {in_data[6:0], in_rd} : in_data;
  assign beat_tag   = in_hdr ? TAG_START : (in_end ? TAG_STOP : TAG_CONT);
  assign out_last   = out_valid && (rd_q == total_q - 1'b1);
  assign out_words  = total_q;

  i2c_pack_pos #(.DEPTH(DEPTH)) u_pos (
    .clk(clk), .rst_n(rst_n), .step(acc), .clear(batch_done),
    .word_idx(word_idx), .slot_idx(slot_idx), .ovf(ovf)
  );

  i2c_pack_wbuf #(.DEPTH(DEPTH)) u_buf (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_word(word_idx),
    .wr_slot(slot_idx), .wr_byte(beat_byte), .wr_tag(beat_tag),
    .rd_idx(rd_q), .rd_data(out_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= ST_FILL;
      total_q <= '0;
      rd_q    <= '0;
      err_o   <= 1'b0;
    end else begin
      err_o <= 1'b0;
      case (st_q)
        ST_FILL: if (batch_done) begin
          if (reject_now) begin
            err_o <= 1'b1;
          end else begin
            st_q    <= ST_SEND;
            total_q <= word_idx + 1'b1;
            rd_q    <= '0;
          end
        end
        default: if (out_ready) begin
          if (out_last) st_q <= ST_FILL;
          else          rd_q <= rd_q + 1'b1;
        end
      endcase
    end
  end

  // R7
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last));
  // R7
  last_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && out_last |=> !out_valid && in_ready);
  // R4
  low_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_data[1:0] == 2'b00);
  // R3
  final_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_last |-> (out_data[3:2] != 2'b10)
      && !(out_data[5:4] == 2'b10 && out_data[3:2] == 2'b00)
      && !(out_data[7:6] == 2'b10 && out_data[5:4] == 2'b00));
  // R6
  reject_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> !out_valid && $past(in_valid && in_end));
endmodule

// File: tb/tb_i2c_cmd_packer.sv
module tb_i2c_cmd_packer;
  localparam int BUF_BYTES = 32;
  localparam int DEPTH = BUF_BYTES / 4;
  localparam int WW = $clog2(DEPTH + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_hdr = 1'b0, in_rd = 1'b0, in_end = 1'b0;
  logic [7:0] in_data = '0;
  logic in_ready, out_valid, out_last, err_o;
  logic out_ready = 1'b0;
  logic [31:0] out_data;
  logic [WW-1:0] out_words;

  always #2 clk = ~clk;

  i2c_cmd_packer #(.BUF_BYTES(BUF_BYTES)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_hdr(in_hdr), .in_rd(in_rd), .in_data(in_data), .in_end(in_end),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_last(out_last), .out_words(out_words), .err_o(err_o)
  );

  int errs = 0, checks = 0;
  bit [7:0] bb [64];
  bit       bh [64];
  int nb = 0;
  logic [31:0] got [32];
  bit  got_last [32];
  int  got_cnt [32];
  int  ngot = 0, overlap = 0;
  bit  err_seen = 0;

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  function automatic logic [31:0] exp_word(int w);
    logic [31:0] r = '0;
    for (int s = 0; s < 3; s++) begin
      int i = w * 3 + s;
      if (i < nb) begin
        logic [1:0] t = bh[i] ? 2'b11 : ((i == nb - 1) ? 2'b01 : 2'b10);
        r |= 32'(bb[i]) << (24 - 8 * s);
        r |= 32'(t) << (6 - 2 * s);
      end
    end
    return r;
  endfunction

  task automatic add_msg(bit [6:0] addr, bit rd, int len);
    bh[nb] = 1'b1; bb[nb] = {addr, rd}; nb++;
    for (int j = 0; j < len; j++) begin
      bh[nb] = 1'b0; bb[nb] = 8'($urandom); nb++;
    end
  endtask

  always @(negedge clk) begin
    out_ready = ($urandom % 4) != 0;
    #1;
    if (out_valid && in_ready) overlap++;
    if (err_o) err_seen = 1'b1;
    if (out_valid && out_ready && ngot < 32) begin
      got[ngot] = out_data;
      got_last[ngot] = out_last;
      got_cnt[ngot] = int'(out_words);
      ngot++;
    end
  end

  task automatic run_batch(string tag);
    int ew = (nb + 2) / 3;
    bit rej = (4 * ew) > BUF_BYTES;
    ngot = 0; err_seen = 1'b0;
    for (int i = 0; i < nb; i++) begin
      @(negedge clk);
      while (!in_ready) @(negedge clk);
      in_valid = 1'b1;
      in_hdr   = bh[i];
      in_rd    = bh[i] ? bb[i][0] : 1'b0;
      in_data  = bh[i] ? {1'b0, bb[i][7:1]} : bb[i];
      in_end   = (i == nb - 1);
      @(posedge clk);
    end
    @(negedge clk);
    in_valid = 1'b0; in_end = 1'b0;
    for (int k = 0; k < 300; k++) begin
      if (rej ? err_seen : (ngot == ew)) break;
      @(negedge clk);
    end
    repeat (4) @(negedge clk);
    if (rej) begin
      chk(err_seen, {"R6 err pulse ", tag}, 32'(err_seen), 1);
      chk(ngot == 0, {"R6 no words ", tag}, ngot, 0);
    end else begin
      chk(!err_seen, {"R6 no err ", tag}, 32'(err_seen), 0);
      chk(ngot == ew, {"R5 word count ", tag}, ngot, ew);
      for (int w = 0; w < ew && w < ngot; w++) begin
        chk(got[w] == exp_word(w), {"R1 R2 R3 R4 word ", tag}, got[w], exp_word(w));
        chk(got_last[w] == (w == ew - 1), {"R7 last flag ", tag}, 32'(got_last[w]), 32'(w == ew - 1));
        chk(got_cnt[w] == ew, {"R5 out_words ", tag}, got_cnt[w], ew);
      end
    end
    chk(overlap == 0, {"R8 in_ready low while sending ", tag}, overlap, 0);
    chk(in_ready && !out_valid, {"R8 ready after batch ", tag}, {in_ready, out_valid}, 2'b10);
    nb = 0;
  endtask

  initial begin
    #(4 * 150000);
    errs++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R9
    chk(in_ready && !out_valid && !err_o, "R9 reset state",
        {in_ready, out_valid, err_o}, 3'b100);
    rst_n = 1'b1;
    // R1 single read header: 0x50 read -> 0xA10000C0
    add_msg(7'h50, 1'b1, 0);
    run_batch("single header");
    chk(exp_word(0) == 32'h0, "R1 model reset", exp_word(0), 0);
    // R2 R3 write of four bytes spans two words
    add_msg(7'h3C, 1'b0, 4);
    run_batch("two words");
    // R3 last message empty keeps START
    add_msg(7'h12, 1'b0, 2);
    add_msg(7'h13, 1'b1, 0);
    run_batch("empty tail");
    // R5 exact capacity: 24 beats
    add_msg(7'h21, 1'b0, 11);
    add_msg(7'h22, 1'b0, 11);
    run_batch("full buffer");
    // R6 one beat beyond capacity
    add_msg(7'h21, 1'b0, 12);
    add_msg(7'h22, 1'b1, 11);
    run_batch("overflow");
    // R2 small batch right after rejection
    add_msg(7'h7F, 1'b1, 1);
    run_batch("after reject");
    for (int b = 0; b < 40; b++) begin
      int nm = 1 + $urandom % 4;
      for (int m = 0; m < nm; m++)
        add_msg(7'($urandom), 1'($urandom), $urandom % 7);
      run_batch("random");
    end
    finish_run();
  end
endmodule